// File: doc/BRIEF.md
# Dual-Line Serial Flash Read Front End

This block is the target side of a serial flash interface, covering only the commands that return data. It oversamples chip select, serial clock, hold and the two data lines with a faster system clock. It decodes an 8-bit opcode and collects a 24-bit address, either one bit per clock or two bits per clock. It then counts the dummy clocks the opcode calls for and streams bytes back on one line or on two. The bytes come from a byte-wide memory read port that has one cycle of latency.

Besides the four memory reads, the block answers a status read with a repeating copy of an externally supplied status byte. It also answers two identification commands with fixed, repeating byte patterns. The block works in clock-idle-low and clock-idle-high serial modes, and it supports a hold pause that freezes the transfer. Erase, program and status writes are handled elsewhere.

Top module: `dual_read_flash_front`

## Requirements
- R1: While chip select is high, and after reset, both output enables (io0_oe, io1_oe) are low.
- R2: The serial clock level when chip select falls picks the mode: low for idle-low, high for idle-high. In idle-high mode the first falling edge is ignored. Both modes return identical data for identical commands.
- R3: Opcode 03h is followed by a 24-bit address, MSB first on io0_in. Data starts at the falling edge after the last address bit, one bit per falling edge, MSB first, on io1_out. Bytes are prefetched from the memory port, which has one cycle of latency.
- R4: Opcode 0Bh is a single-line read with 8 dummy clocks between the address and the data.
- R5: Opcode 3Bh takes a single-line address and 8 dummy clocks. It then sends each byte in 4 falling edges: bits 7,5,3,1 on io1_out and bits 6,4,2,0 on io0_out, highest pair first.
- R6: Opcode BBh takes the address two bits per clock in 12 clocks: A23,A21..A1 on io1_in and A22,A20..A0 on io0_in, highest pair first. It then waits 4 dummy clocks with both lines undriven, and sends data on two lines as in R5.
- R7: Address bits 23 to 19 are ignored. The address increments after each byte and wraps from 07FFFFh to 000000h.
- R8: Opcode 05h sends status_in, MSB first on io1_out, repeated for as long as clocks continue.
- R9: Opcode 9Fh sends the bytes 62h, 16h, 13h, 00h and repeats that 4-byte sequence.
- R10: Opcode ABh followed by 3 don't-care bytes sends 3Eh repeatedly.
- R11: If hold falls while the serial clock is low, the outputs float and clock edges are ignored until hold rises. The transfer then resumes at the same bit.
- R12: A rising chip select ends any hold and resets the command decoder. An unrecognised opcode never drives the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| hold_n | input | 1 | Hold request, active low |
| io0_in | input | 1 | Data line 0 as seen from the pin |
| io1_in | input | 1 | Data line 1 as seen from the pin |
| status_in | input | 8 | Status byte returned by opcode 05h |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_addr |
| mem_addr | output | AW | Byte address to the memory read port |
| io0_out | output | 1 | Output value for data line 0 |
| io1_out | output | 1 | Output value for data line 1 |
| io0_oe | output | 1 | Drive enable for data line 0 |
| io1_oe | output | 1 | Drive enable for data line 1 |

## Verification
The bench goes after the step from the last address or dummy clock to the first data bit. A design that is off by one clock would shift every byte by a bit. It checks the pairing of bits on the two lines, both for the dual address and for dual data, where swapped lines would scramble the nibbles. It reads across the top of memory with the ignored upper address bits set, which catches a design that does not wrap or that keeps bit 19. It also pauses a read in the middle of a byte and then drops chip select while hold is still low. A design that counts clocks during the pause, or keeps the hold after deselection, would return wrong bits or stay silent.

// File: rtl/dual_read_flash_front.sv
`timescale 1ns/1ps
module dual_read_flash_front #(
  parameter int AW = 19,
  parameter logic [7:0] ID_MFR = 8'h62,
  parameter logic [7:0] ID_TYPE = 8'h16,
  parameter logic [7:0] ID_CAP = 8'h13,
  parameter logic [7:0] ID_EXT = 8'h00,
  parameter logic [7:0] ID_SHORT = 8'h3E
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          hold_n,
  input  logic          io0_in,
  input  logic          io1_in,
  input  logic [7:0]    status_in,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          io0_out,
  output logic          io1_out,
  output logic          io0_oe,
  output logic          io1_oe
);
  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DUMMY, S_DATA, S_IGN} st_t;
  typedef enum logic [1:0] {K_MEM, K_STAT, K_JID, K_SID} kind_t;

  logic [1:0] cs_m, sck_m, hold_m, io0_m, io1_m;
  logic cs_d, sck_d, hold_d;
  logic cs_s, sck_s, hold_s, io0_s, io1_s;
  logic sck_r, sck_f, held, armed, driven, dual_a, dual_d;
  st_t st;
  kind_t kind;
  logic [4:0] cnt, dmy;
  logic [7:0] op, opn, nxt, cur, ob, src;
  logic [23:0] addr;
  logic [2:0] opos;
  logic [1:0] fcnt;

  assign cs_s = cs_m[1];
  assign sck_s = sck_m[1];
  assign hold_s = hold_m[1];
  assign io0_s = io0_m[1];
  assign io1_s = io1_m[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_m <= 2'b11; sck_m <= 2'b00; hold_m <= 2'b11; io0_m <= 2'b00; io1_m <= 2'b00;
      cs_d <= 1'b1; sck_d <= 1'b0; hold_d <= 1'b1;
    end else begin
      cs_m <= {cs_m[0], cs_n}; sck_m <= {sck_m[0], sck}; hold_m <= {hold_m[0], hold_n};
      io0_m <= {io0_m[0], io0_in}; io1_m <= {io1_m[0], io1_in};
      cs_d <= cs_s; sck_d <= sck_s; hold_d <= hold_s;
    end

  assign sck_r = ~cs_s & ~held & sck_s & ~sck_d;
  assign sck_f = ~cs_s & ~held & ~sck_s & sck_d;
  assign opn = {op[6:0], io0_s};
  assign ob = (opos == 3'd0) ? nxt : cur;
  assign mem_addr = addr[AW-1:0];

  always_comb
    case (kind)
      K_MEM:   src = mem_rdata;
      K_STAT:  src = status_in;
      K_JID:   case (addr[1:0])
                 2'd0: src = ID_MFR;
                 2'd1: src = ID_TYPE;
                 2'd2: src = ID_CAP;
                 default: src = ID_EXT;
               endcase
      default: src = ID_SHORT;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_CMD; kind <= K_MEM; cnt <= '0; dmy <= '0; op <= '0; addr <= '0;
      nxt <= '0; cur <= '0; opos <= '0; fcnt <= '0; held <= 1'b0; armed <= 1'b0;
      driven <= 1'b0; dual_a <= 1'b0; dual_d <= 1'b0; io0_out <= 1'b0; io1_out <= 1'b0;
    end else if (cs_s) begin
      st <= S_CMD; cnt <= '0; opos <= '0; fcnt <= '0; held <= 1'b0;
      driven <= 1'b0; dual_d <= 1'b0; armed <= 1'b0;
    end else begin
      if (cs_d) armed <= sck_s;
      if (~hold_s & hold_d & ~sck_s) held <= 1'b1;
      else if (hold_s & ~hold_d) held <= 1'b0;
      if (fcnt != 2'd0) fcnt <= fcnt - 2'd1;
      if (fcnt == 2'd1) begin
        nxt <= src;
        addr[AW-1:0] <= addr[AW-1:0] + AW'(1);
      end
      if (sck_r) begin
        armed <= 1'b0;
        case (st)
          S_CMD: begin
            op <= opn;
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0; kind <= K_MEM; dual_a <= 1'b0; dual_d <= 1'b0; dmy <= '0;
              st <= S_ADDR;
              case (opn)
                8'h03: ;
                8'h0B: dmy <= 5'd8;
                8'h3B: begin dmy <= 5'd8; dual_d <= 1'b1; end
                8'hBB: begin dmy <= 5'd4; dual_d <= 1'b1; dual_a <= 1'b1; end
                8'hAB: kind <= K_SID;
                8'h05: begin kind <= K_STAT; st <= S_DATA; fcnt <= 2'd2; end
                8'h9F: begin kind <= K_JID; st <= S_DATA; fcnt <= 2'd2; addr <= '0; end
                default: st <= S_IGN;
              endcase
            end
          end
          S_ADDR: begin
            addr <= dual_a ? {addr[21:0], io1_s, io0_s} : {addr[22:0], io0_s};
            cnt <= cnt + 5'd1;
            if (cnt == (dual_a ? 5'd11 : 5'd23)) begin
              cnt <= '0;
              if (dmy == 5'd0) begin st <= S_DATA; fcnt <= 2'd2; end
              else st <= S_DUMMY;
            end
          end
          S_DUMMY: begin
            cnt <= cnt + 5'd1;
            if (cnt == dmy - 5'd1) begin st <= S_DATA; fcnt <= 2'd2; end
          end
          default: ;
        endcase
      end
      if (sck_f) begin
        if (armed) armed <= 1'b0;
        else if (st == S_DATA) begin
          driven <= 1'b1;
          io1_out <= ob[7];
          if (dual_d) begin
            io0_out <= ob[6];
            cur <= {ob[5:0], 2'b00};
            opos <= (opos == 3'd3) ? 3'd0 : opos + 3'd1;
          end else begin
            cur <= {ob[6:0], 1'b0};
            opos <= opos + 3'd1;
          end
          if (opos == 3'd0) fcnt <= 2'd2;
        end
      end
    end

  assign io1_oe = ~cs_s & ~held & driven & (st == S_DATA);
  assign io0_oe = io1_oe & dual_d;

  AST_FLOAT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !io1_oe && !io0_oe); // R1
  AST_IO0_DUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> io1_oe); // R5
  AST_OUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_f) |-> $stable({io1_out, io0_out})); // R3
  AST_PREFETCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sck_f && st == S_DATA && !armed && opos == 3'd0 |-> fcnt == 2'd0); // R3
endmodule

// File: tb/sim_dual_read_flash_front.sv
`timescale 1ns/1ps
module sim_dual_read_flash_front;
  localparam int AW = 19;
  localparam int H = 6;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
  logic io0_in = 1'b0, io1_in = 1'b0;
  logic [7:0] status_in = 8'hA5, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic io0_out, io1_out, io0_oe, io1_oe;
  logic s1, s0, e1, e0;
  bit mode3_g;
  int tests = 0, fails = 0, cyc = 0, idle = 0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  dual_read_flash_front #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .io0_in(io0_in), .io1_in(io1_in), .status_in(status_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .io0_out(io0_out), .io1_out(io1_out), .io0_oe(io0_oe), .io1_oe(io1_oe));

  function automatic logic [7:0] fmem(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b10110};
  endfunction

  always_ff @(posedge clk) mem_rdata <= fmem(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cs_n) idle++; else idle = 0;
    if (idle > 3) chk("R1 deselected float", {30'd0, io1_oe, io0_oe}, 32'd0);
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    mode3_g = m3;
    @(negedge clk);
    sck = m3;
    wait_n(H);
    cs_n = 1'b0;
    wait_n(H);
    if (m3) begin sck = 1'b0; wait_n(H); end
  endtask

  task automatic desel();
    wait_n(H);
    if (mode3_g) begin sck = 1'b1; wait_n(H); end
    cs_n = 1'b1;
    wait_n(2 * H);
  endtask

  task automatic bclk(input logic d1, input logic d0);
    io1_in = d1; io0_in = d0;
    wait_n(H);
    s1 = io1_out; s0 = io0_out; e1 = io1_oe; e0 = io0_oe;
    sck = 1'b1;
    wait_n(H);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bclk(1'b0, b[i]);
  endtask

  task automatic recv(input bit dual, output logic [7:0] b, output logic ok);
    ok = 1'b1; b = '0;
    if (dual)
      for (int i = 0; i < 4; i++) begin
        bclk(1'b0, 1'b0); b = {b[5:0], s1, s0};
        if (!(e1 && e0)) ok = 1'b0;
      end
    else
      for (int i = 0; i < 8; i++) begin
        bclk(1'b0, 1'b0); b = {b[6:0], s1};
        if (!(e1 && !e0)) ok = 1'b0;
      end
  endtask

  task automatic read_test(input string tag, input bit m3, input logic [7:0] opc,
                           input logic [23:0] a, input int nd, input bit da, input bit dd, input int n);
    logic [7:0] b; logic ok; logic dz;
    for (int k = 0; k < n; k++) q.push_back(fmem(a[AW-1:0] + AW'(k)));
    sel(m3);
    send_byte(opc);
    if (da) for (int i = 11; i >= 0; i--) bclk(a[2*i+1], a[2*i]);
    else for (int i = 23; i >= 0; i--) bclk(1'b0, a[i]);
    dz = 1'b0;
    for (int i = 0; i < nd; i++) begin bclk(1'b0, 1'b0); dz = dz | e1 | e0; end
    if (nd > 0) chk({tag, " dummy undriven"}, {31'd0, dz}, 32'd0);
    for (int k = 0; k < n; k++) begin
      recv(dd, b, ok);
      chk({tag, " data"}, {24'd0, b}, {24'd0, q.pop_front()});
      chk({tag, " enables"}, {31'd0, ok}, 32'd1);
    end
    desel();
  endtask

  initial begin
    logic [7:0] b; logic ok; logic [7:0] jid [4]; logic anyoe;
    jid[0] = 8'h62; jid[1] = 8'h16; jid[2] = 8'h13; jid[3] = 8'h00;
    wait_n(5);
    chk("R1 reset oe", {30'd0, io1_oe, io0_oe}, 32'd0);
    rst_n = 1'b1;
    wait_n(5);

    read_test("R3 read 03h", 0, 8'h03, 24'h000123, 0, 0, 0, 4);
    read_test("R2 mode3 03h", 1, 8'h03, 24'h000123, 0, 0, 0, 4);
    read_test("R4 fast 0Bh", 0, 8'h0B, 24'h012340, 8, 0, 0, 3);
    read_test("R2 R4 mode3 0Bh", 1, 8'h0B, 24'h012340, 8, 0, 0, 3);
    read_test("R5 dual out 3Bh", 0, 8'h3B, 24'h04A0F1, 8, 0, 1, 4);
    read_test("R6 dual io BBh", 1, 8'hBB, 24'h0355AA, 4, 1, 1, 4);
    read_test("R6 dual io BBh m0", 0, 8'hBB, 24'h02C3A6, 4, 1, 1, 3);
    read_test("R7 wrap 03h", 0, 8'h03, 24'hF7FFFE, 0, 0, 0, 4);
    read_test("R7 wrap BBh", 0, 8'hBB, 24'h8FFFFF, 4, 1, 1, 2);

    sel(0); send_byte(8'h05);
    for (int k = 0; k < 3; k++) begin recv(0, b, ok); chk("R8 status", {23'd0, ok, b}, {23'd0, 1'b1, 8'hA5}); end
    desel();
    status_in = 8'h3C;
    sel(1); send_byte(8'h05);
    for (int k = 0; k < 2; k++) begin recv(0, b, ok); chk("R8 status mode3", {23'd0, ok, b}, {23'd0, 1'b1, 8'h3C}); end
    desel();

    sel(0); send_byte(8'h9F);
    for (int k = 0; k < 6; k++) begin recv(0, b, ok); chk("R9 id sequence", {23'd0, ok, b}, {23'd0, 1'b1, jid[k % 4]}); end
    desel();

    sel(1); send_byte(8'hAB); send_byte(8'h5A); send_byte(8'hC3); send_byte(8'hFF);
    for (int k = 0; k < 3; k++) begin recv(0, b, ok); chk("R10 short id", {23'd0, ok, b}, {23'd0, 1'b1, 8'h3E}); end
    desel();

    q.push_back(fmem(19'h00200)); q.push_back(fmem(19'h00201)); q.push_back(fmem(19'h00202));
    sel(0); send_byte(8'h03); send_byte(8'h00); send_byte(8'h02); send_byte(8'h00);
    recv(0, b, ok); chk("R11 before hold", {24'd0, b}, {24'd0, q.pop_front()});
    b = '0;
    for (int i = 0; i < 3; i++) begin bclk(1'b0, 1'b0); b = {b[6:0], s1}; end
    hold_n = 1'b0;
    wait_n(H);
    anyoe = io1_oe | io0_oe;
    for (int i = 0; i < 4; i++) begin
      sck = 1'b1; wait_n(H); anyoe = anyoe | io1_oe | io0_oe;
      sck = 1'b0; wait_n(H); anyoe = anyoe | io1_oe | io0_oe;
    end
    chk("R11 held floats", {31'd0, anyoe}, 32'd0);
    hold_n = 1'b1;
    wait_n(H);
    for (int i = 0; i < 5; i++) begin bclk(1'b0, 1'b0); b = {b[6:0], s1}; end
    chk("R11 resume byte", {24'd0, b}, {24'd0, q.pop_front()});
    recv(0, b, ok); chk("R11 next byte", {23'd0, ok, b}, {23'd0, 1'b1, q.pop_front()});
    desel();

    sel(0); send_byte(8'h03); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00);
    recv(0, b, ok);
    hold_n = 1'b0;
    wait_n(H);
    chk("R12 held before deselect", {30'd0, io1_oe, io0_oe}, 32'd0);
    desel();
    sel(0); send_byte(8'h05);
    recv(0, b, ok); chk("R12 hold cleared by deselect", {23'd0, ok, b}, {23'd0, 1'b1, 8'h3C});
    desel();
    hold_n = 1'b1;
    wait_n(H);

    sel(0); send_byte(8'hFF);
    anyoe = 1'b0;
    for (int i = 0; i < 16; i++) begin bclk(1'b0, 1'b0); anyoe = anyoe | e1 | e0; end
    chk("R12 unknown opcode silent", {31'd0, anyoe}, 32'd0);
    desel();

    read_test("R12 decoder reset after junk", 1, 8'h03, 24'h000042, 0, 0, 0, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule